// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory with Control-Pin Mode Decoding

This block is a synthesizable behavioural model of a byte-wide one-time-programmable memory, together with the logic that turns its control pins into an operating mode. The control pins are an active-low chip enable, an active-low output enable and an active-low program strobe. Two digital flags stand in for analog conditions: one says that the programming supply is present, and the other says that the identification high voltage is on address bit 9. The analog levels, the electrical timing and the power behaviour are not modelled.

The array is `2**ADDR_W` bytes. Setting `ADDR_W = 17` gives the full 128K x 8 part, and the default is smaller so that elaboration stays light. Every byte starts as 0xFF. A program operation can only clear bits: the incoming byte is ANDed into the stored byte, and the write is committed when the program strobe rises. An identification mode replaces the array output with fixed codes that carry odd parity and are selected by A1 and A0.

The output side is a data byte plus a drive flag that stands in for a tri-state bus. When the flag is low the data byte is forced to 0x00. All outputs are registered. The values seen after clock edge k reflect the inputs sampled at edge k.

Top module: `otp_byte_mem`

## Requirements
- R1: After reset, every byte reads 0xFF.
- R2: A committed program operation stores `old & din`. A bit that is 0 never returns to 1.
- R3: When `ce_n` is 1 and `vpp_on` is 0 (standby), `dout_en` is 0 and `dout` is 0x00 whatever `oe_n` is.
- R4: Read mode drives the stored byte with `dout_en` = 1, one edge after the inputs are sampled. Read mode is `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `id_hv`=0, with `pgm_n` a don't-care.
- R5: Output disable drives `dout_en` = 0 and `dout` = 0x00. Output disable is `ce_n`=0, `oe_n`=1 and `vpp_on`=0.
- R6: Program mode is `vpp_on`=1, `ce_n`=0, `oe_n`=1 and `pgm_n`=0. In program mode the outputs do not drive. The address and data of the last program-mode cycle are committed on the first cycle in which `pgm_n` is 1.
- R7: When `vpp_on` is 1 and `ce_n` is 1 (inhibit), a program pulse changes nothing and the outputs do not drive.
- R8: Program verify drives the stored byte. Program verify is `vpp_on`=1, `ce_n`=0, `oe_n`=0 and `pgm_n`=1.
- R9: Identification mode is `id_hv`=1 with read-mode pins. In this mode the output is a fixed code instead of array data: A1=1 with A0=0 gives 0x1C, A1=1 with A0=1 gives 0x01, and A1=0 gives 0x7F. The array is not altered.
- R10: Every identification byte has odd parity over bits 7..0, with bit 7 acting as the parity bit.
- R11: When `vpp_on` is 1 and `ce_n` is 0, the combinations in which `oe_n` and `pgm_n` are equal are undefined. They do not drive the outputs and write nothing.
- R12: If a program pulse is abandoned (chip enable, supply or output enable leaves program mode while `pgm_n` is still 0), the later rise of `pgm_n` commits nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets the whole array to ones |
| addr | input | ADDR_W | Byte address; bit 1 and bit 0 also select the identification code |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pgm_n | input | 1 | Program strobe, active low; a write commits when it rises |
| vpp_on | input | 1 | Programming supply present |
| id_hv | input | 1 | Identification high voltage present on address bit 9 |
| din | input | 8 | Byte to program |
| dout | output | 8 | Output byte; 0x00 when not driven |
| dout_en | output | 1 | Output drive flag, standing in for the tri-state enable |

## Verification
The hardest case to reach from the ports is a program pulse that is abandoned partway through. It can end in two ways: chip enable rises first and the strobe rises later, or the strobe rises while the pins still hold the program combination. Only the second of these may change the array. The stimulus builds both orderings on purpose. It then reads the target byte back through read mode, so the difference shows up as 0xFF against a cleared byte. The identification codes are also read at addresses whose bytes were already programmed, which shows that the fixed codes take the place of array data.

// File: rtl/otp_pkg.sv
package otp_pkg;

   localparam int BYTE_W = 8;

   typedef enum logic [2:0] {
      M_STANDBY,
      M_INHIBIT,
      M_DISABLE,
      M_READ,
      M_IDENT,
      M_PROGRAM,
      M_VERIFY,
      M_UNDEF
   } otp_mode_e;

   // Build an identification byte: seven code bits plus a top bit giving odd parity.
   function automatic logic [BYTE_W-1:0] odd_code(input logic [BYTE_W-2:0] low);
      return {~(^low), low};
   endfunction

endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
   import otp_pkg::*;
#(
   parameter bit ID_EN = 1'b1
) (
   input  logic      ce_n,
   input  logic      oe_n,
   input  logic      pgm_n,
   input  logic      vpp_on,
   input  logic      id_hv,
   output otp_mode_e mode,
   output logic      drive
);

   always_comb begin
      if (ce_n) begin
         mode = vpp_on ? M_INHIBIT : M_STANDBY;
      end else if (vpp_on) begin
         if (oe_n && !pgm_n)      mode = M_PROGRAM;
         else if (!oe_n && pgm_n) mode = M_VERIFY;
         else                     mode = M_UNDEF;
      end else if (oe_n) begin
         mode = M_DISABLE;
      end else begin
         mode = (ID_EN && id_hv) ? M_IDENT : M_READ;
      end
   end

   assign drive = (mode == M_READ) || (mode == M_VERIFY) || (mode == M_IDENT);

endmodule

// File: rtl/otp_byte_array.sv
module otp_byte_array
   import otp_pkg::*;
#(
   parameter int ADDR_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [BYTE_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   generate
      if (ADDR_W < 2 || ADDR_W > 17) begin : g_bad_depth
         $error("otp_byte_array: ADDR_W must lie in 2..17");
      end
   endgenerate

   logic [BYTE_W-1:0] mem [DEPTH];
   logic [BYTE_W-1:0] wr_old;

   assign wr_old  = mem[wr_addr];
   assign rd_data = mem[rd_addr];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (wr_en) begin
         mem[wr_addr] <= wr_old & wr_data;
      end
   end

   // R2: a write may only clear bits of the byte it targets
   p_no_set_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ((mem[$past(wr_addr)] & ~$past(wr_old)) == '0));

endmodule

// File: rtl/otp_id_rom.sv
module otp_id_rom
   import otp_pkg::*;
#(
   parameter logic [BYTE_W-2:0] MFR_LOW  = 7'h1C,
   parameter logic [BYTE_W-2:0] DEV_LOW  = 7'h01,
   parameter logic [BYTE_W-2:0] CONT_LOW = 7'h7F
) (
   input  logic              a1,
   input  logic              a0,
   output logic [BYTE_W-1:0] code
);

   localparam logic [BYTE_W-1:0] MFR_CODE  = odd_code(MFR_LOW);
   localparam logic [BYTE_W-1:0] DEV_CODE  = odd_code(DEV_LOW);
   localparam logic [BYTE_W-1:0] CONT_CODE = odd_code(CONT_LOW);

   always_comb begin
      if (!a1)     code = CONT_CODE;
      else if (a0) code = DEV_CODE;
      else         code = MFR_CODE;
   end

   // R10: every identification byte carries odd parity
   always_comb begin
      a_id_odd_r10: assert (^code == 1'b1);
   end

endmodule

// File: rtl/otp_byte_mem.sv
module otp_byte_mem
   import otp_pkg::*;
#(
   parameter int                ADDR_W   = 10,
   parameter bit                ID_EN    = 1'b1,
   parameter logic [BYTE_W-2:0] MFR_LOW  = 7'h1C,
   parameter logic [BYTE_W-2:0] DEV_LOW  = 7'h01,
   parameter logic [BYTE_W-2:0] CONT_LOW = 7'h7F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              pgm_n,
   input  logic              vpp_on,
   input  logic              id_hv,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] dout,
   output logic              dout_en
);

   generate
      if (ADDR_W < 2) begin : g_bad_addr
         $error("otp_byte_mem: A1 and A0 are needed for identification");
      end
   endgenerate

   otp_mode_e         mode;
   logic              drive;
   logic              prog_q;
   logic [ADDR_W-1:0] pa_q;
   logic [BYTE_W-1:0] pd_q;
   logic              commit;
   logic [BYTE_W-1:0] rd_data;
   logic [BYTE_W-1:0] id_code;
   logic [BYTE_W-1:0] out_nxt;

   otp_mode_decode #(.ID_EN(ID_EN)) u_dec (
      .ce_n   (ce_n),
      .oe_n   (oe_n),
      .pgm_n  (pgm_n),
      .vpp_on (vpp_on),
      .id_hv  (id_hv),
      .mode   (mode),
      .drive  (drive)
   );

   // Remember the last program-mode cycle; the strobe rising ends the pulse.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prog_q <= 1'b0;
         pa_q   <= '0;
         pd_q   <= '1;
      end else begin
         prog_q <= (mode == M_PROGRAM);
         if (mode == M_PROGRAM) begin
            pa_q <= addr;
            pd_q <= din;
         end
      end
   end

   assign commit = prog_q && pgm_n;

   otp_byte_array #(.ADDR_W(ADDR_W)) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (commit),
      .wr_addr (pa_q),
      .wr_data (pd_q),
      .rd_addr (addr),
      .rd_data (rd_data)
   );

   generate
      if (ID_EN) begin : g_id
         otp_id_rom #(
            .MFR_LOW  (MFR_LOW),
            .DEV_LOW  (DEV_LOW),
            .CONT_LOW (CONT_LOW)
         ) u_id (
            .a1   (addr[1]),
            .a0   (addr[0]),
            .code (id_code)
         );
      end else begin : g_no_id
         assign id_code = '0;
      end
   endgenerate

   always_comb begin
      case (mode)
         M_READ, M_VERIFY: out_nxt = rd_data;
         M_IDENT:          out_nxt = id_code;
         default:          out_nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dout    <= '0;
         dout_en <= 1'b0;
      end else begin
         dout    <= out_nxt;
         dout_en <= drive;
      end
   end

   // R3: a deselected device never drives
   p_standby_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ce_n) |-> !dout_en);

   // R5: an undriven bus carries zeros
   p_quiet_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0));

   // R6: a commit follows a cycle holding the program pin combination
   p_commit_after_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> ($past(vpp_on) && !$past(ce_n) && $past(oe_n) && !$past(pgm_n) && pgm_n));

   // R10: identification output has odd parity
   p_id_parity_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_IDENT) |-> (dout_en && (^dout == 1'b1)));

   // R11: undefined pin combinations never drive
   p_undef_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode) == M_UNDEF) |-> !dout_en);

endmodule

// File: tb/otp_byte_mem_tb_top.sv
`timescale 1ns/1ps
module otp_byte_mem_tb_top;

   localparam int AW = 10;

   typedef struct {
      bit         chk;
      bit         par;
      logic       en;
      logic [7:0] d;
      string      tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp_on = 1'b0, id_hv = 1'b0;
   logic [7:0]    din = 8'hFF;
   logic [7:0]    dout;
   logic          dout_en;

   int   checks = 0;
   int   fails  = 0;
   exp_t q[$];
   logic [7:0] mdl [int];

   always #2 clk = ~clk;

   otp_byte_mem #(.ADDR_W(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .pgm_n(pgm_n), .vpp_on(vpp_on), .id_hv(id_hv), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   function automatic logic [7:0] get(input int a);
      return mdl.exists(a) ? mdl[a] : 8'hFF;
   endfunction

   task automatic drive(input logic ce, oe, pgm, vpp, hv, input int a, input logic [7:0] d,
                        input bit chk, input logic en_e, input logic [7:0] d_e,
                        input bit par, input string tag);
      exp_t it;
      @(negedge clk);
      ce_n = ce; oe_n = oe; pgm_n = pgm; vpp_on = vpp; id_hv = hv;
      addr = AW'(a); din = d;
      it.chk = chk; it.par = par; it.en = en_e; it.d = d_e; it.tag = tag;
      q.push_back(it);
   endtask

   task automatic rd(input int a, input string tag);
      drive(0, 0, 1, 0, 0, a, 8'h00, 1, 1'b1, get(a), 0, tag);
   endtask

   task automatic prog(input int a, input logic [7:0] d, input string tag);
      drive(0, 1, 0, 1, 0, a, d, 1, 1'b0, 8'h00, 0, tag);
      drive(0, 1, 0, 1, 0, a, d, 1, 1'b0, 8'h00, 0, tag);
      drive(0, 1, 1, 1, 0, a, d, 1, 1'b0, 8'h00, 0, tag);
      mdl[a] = get(a) & d;
   endtask

   task automatic idle();
      drive(1, 1, 1, 0, 0, 0, 8'hFF, 0, 1'b0, 8'h00, 0, "idle");
   endtask

   initial begin : monitor
      exp_t it;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            it = q.pop_front();
            if (it.chk) begin
               checks++;
               if (dout_en !== it.en || dout !== it.d) begin
                  fails++;
                  $display("FAIL %s: actual en=%b d=%h expected en=%b d=%h",
                           it.tag, dout_en, dout, it.en, it.d);
               end
               if (it.par) begin
                  checks++;
                  if ((^dout) !== 1'b1) begin
                     fails++;
                     $display("FAIL %s parity: actual xor=%b expected 1", it.tag, ^dout);
                  end
               end
            end
         end
      end
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : stim
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // R1: erased state
      rd(0, "R1 addr 0");
      rd(5, "R1 addr 5");
      rd((1 << AW) - 1, "R1 top addr");

      // R3: standby with either output enable
      drive(1, 0, 1, 0, 0, 5, 8'h00, 1, 1'b0, 8'h00, 0, "R3 standby oe low");
      drive(1, 1, 0, 0, 0, 5, 8'h00, 1, 1'b0, 8'h00, 0, "R3 standby oe high");
      // R5: output disable
      drive(0, 1, 1, 0, 0, 5, 8'h00, 1, 1'b0, 8'h00, 0, "R5 output disable");
      drive(0, 1, 0, 0, 0, 5, 8'h00, 1, 1'b0, 8'h00, 0, "R5 disable pgm low");
      rd(5, "R5 no write without supply");

      // R6 and R4: program then read
      prog(5, 8'hA5, "R6 program pulse hiZ");
      rd(5, "R4 read after program");
      // R2: only clears
      prog(5, 8'h5A, "R2 second pulse");
      rd(5, "R2 and result zero");
      prog(7, 8'h0F, "R2 first");
      prog(7, 8'hF3, "R2 second");
      rd(7, "R2 and result 0x03");
      prog(7, 8'hFF, "R2 all ones");
      rd(7, "R2 ones restore nothing");

      // R8: verify
      drive(0, 0, 1, 1, 0, 7, 8'h00, 1, 1'b1, 8'h03, 0, "R8 verify addr 7");
      drive(0, 0, 1, 1, 0, 9, 8'h00, 1, 1'b1, 8'hFF, 0, "R8 verify erased");

      // R7: inhibit
      drive(1, 1, 0, 1, 0, 9, 8'h00, 1, 1'b0, 8'h00, 0, "R7 inhibit pulse");
      drive(1, 1, 0, 1, 0, 9, 8'h00, 1, 1'b0, 8'h00, 0, "R7 inhibit pulse");
      drive(1, 1, 1, 1, 0, 9, 8'h00, 1, 1'b0, 8'h00, 0, "R7 inhibit rise");
      rd(9, "R7 inhibited byte unchanged");

      // R11: undefined combinations
      drive(0, 0, 0, 1, 0, 9, 8'h00, 1, 1'b0, 8'h00, 0, "R11 oe and pgm low");
      drive(0, 0, 1, 1, 0, 9, 8'h00, 1, 1'b1, 8'hFF, 0, "R11 then verify");
      drive(0, 1, 1, 1, 0, 9, 8'h00, 1, 1'b0, 8'h00, 0, "R11 oe and pgm high");
      rd(9, "R11 no write");

      // R12: abandoned pulse
      drive(0, 1, 0, 1, 0, 11, 8'h00, 1, 1'b0, 8'h00, 0, "R12 pulse start");
      drive(1, 1, 0, 1, 0, 11, 8'h00, 1, 1'b0, 8'h00, 0, "R12 ce rises first");
      drive(1, 1, 1, 1, 0, 11, 8'h00, 1, 1'b0, 8'h00, 0, "R12 strobe rises late");
      rd(11, "R12 abandoned pulse commits nothing");
      // strobe rising together with ce still commits
      drive(0, 1, 0, 1, 0, 12, 8'h3C, 1, 1'b0, 8'h00, 0, "R6 pulse");
      drive(1, 1, 1, 1, 0, 12, 8'h3C, 1, 1'b0, 8'h00, 0, "R6 strobe with ce");
      mdl[12] = 8'h3C;
      rd(12, "R6 commit on strobe rise");

      // R9 and R10: identification over programmed bytes
      drive(0, 0, 1, 0, 1, 6, 8'h00, 1, 1'b1, 8'h1C, 1, "R9 manufacturer code");
      drive(0, 0, 1, 0, 1, 3, 8'h00, 1, 1'b1, 8'h01, 1, "R9 device code");
      drive(0, 0, 1, 0, 1, 5, 8'h00, 1, 1'b1, 8'h7F, 1, "R9 continuation a0 high");
      drive(0, 0, 1, 0, 1, 4, 8'h00, 1, 1'b1, 8'h7F, 1, "R10 continuation a0 low");
      drive(0, 1, 1, 0, 1, 6, 8'h00, 1, 1'b0, 8'h00, 0, "R9 id with oe high");
      rd(5, "R9 array untouched by id");

      // R4: pattern sweep
      for (int i = 0; i < 16; i++) prog(32 + i, 8'((i * 17) ^ 8'h3C), "R4 sweep program");
      for (int i = 0; i < 16; i++) rd(32 + i, "R4 sweep read");
      rd(31, "R4 neighbour erased");

      idle();
      idle();
      wait (q.size() == 0);
      @(posedge clk);
      #2;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule